// File: doc/BRIEF.md
# Raster-op and alpha blend pixel unit

This unit is the per-pixel combine step of a bit-block transfer engine. Each beat carries one source pixel and one destination pixel. A pixel is a word of NUM_CH colour channels of CH_W bits each, with channel 0 in the least significant bits. Each pixel also has its own CH_W-bit alpha. The unit first merges the two colour words with a 4-bit logical raster operation. It then blends that raster result with the destination colour under one of four alpha modes. Last, it applies a per-bit write mask, so destination bits outside the mask keep their old value. Address generation, strides and memory access belong to the surrounding engine.

Pixel pairs enter on a valid/ready stream and results leave on a second valid/ready stream. The raster-op code, blend mode and write mask are plain inputs. They are sampled in the same cycle as the pixel pair they apply to and then travel with it, so they may change on every beat. The unit has three register stages and accepts one pixel per cycle.

Back-pressure rules are as follows. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the whole pipeline holds: `in_ready` is low, and `out_pix` and `out_valid` stay as they are until the result is taken. No beat is lost or duplicated.

Top module: `pxc_top`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, with no accepted input, `out_valid` is 0 and `in_ready` is 1.
- R2: The raster result bit i equals `cfg_rop[{dst[i], src[i]}]`, applied to every colour bit. So code 0000 gives all zeros, 1111 all ones, 0110 XOR, 1001 XNOR, 1010 the source, 1100 the destination, 1110 OR, 0101 NOT source and 0011 NOT destination.
- R3: Blend mode 00 outputs the raster result unchanged in every channel.
- R4: In blend mode 01, a source alpha of 0 outputs the destination channel. Any other source alpha sa outputs ((sa+1)*r + (255-sa)*d)/256, truncated, where r is the raster-result channel and d is the destination channel.
- R5: In blend mode 10, a destination alpha of 0 outputs the raster-result channel. Any other destination alpha da outputs ((255-da)*r + (da+1)*d)/256, truncated.
- R6: In blend mode 11, each term is weighted on its own: an alpha of 0 gives 0, an alpha of 255 gives pixel*256, and any other alpha gives pixel*(alpha+1). The channel is the sum divided by 256, truncated and saturated at 255.
- R7: Each output bit is (blend AND mask) OR (destination AND NOT mask), using the `cfg_mask` sampled with the beat.
- R8: A beat accepted at clock edge k has its result with `out_valid` high after edge k+2, so it can be taken at edge k+3. Back-to-back beats with `out_ready` high give one result per cycle, in input order.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_pix` and `out_valid` stay unchanged. No beat is lost.
- R10: The raster code, blend mode and mask are captured with each accepted beat. Changing them on later beats does not affect beats already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A source/destination pair is offered |
| in_ready | output | 1 | The unit can take a pair this cycle |
| in_src | input | NUM_CH*CH_W | Source colour word |
| in_src_alpha | input | CH_W | Source alpha |
| in_dst | input | NUM_CH*CH_W | Destination colour word |
| in_dst_alpha | input | CH_W | Destination alpha |
| cfg_rop | input | 4 | Raster-op truth table, indexed by {dst bit, src bit} |
| cfg_blend | input | 2 | Blend mode: 00 source, 01 source alpha, 10 destination alpha, 11 additive |
| cfg_mask | input | NUM_CH*CH_W | Destination write mask, 1 = bit may change |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_pix | output | NUM_CH*CH_W | Resulting colour word |

## Verification
All sixteen raster codes are run on source and destination words with distinct bit pairs in every position. This tells the truth-table indexing apart from a swapped {src, dst} order. Alpha values of 0, 1, 254, 255 and mid-range are run in each blend mode to separate the special cases from the plain weighting formula, and to show that truncation and the saturation of the additive mode work. Partial masks and a burst with raster code, mode and mask changing on every beat under random back-pressure show masking and configuration capture. Long constrained-random runs with a stalling sink show ordering, latency and that no beat is dropped.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

  typedef enum logic [1:0] {
    BLEND_PASS      = 2'b00,
    BLEND_BY_SRC_A  = 2'b01,
    BLEND_BY_DST_A  = 2'b10,
    BLEND_ADDITIVE  = 2'b11
  } blend_mode_e;

  localparam int ROP_W = 4;

endpackage

// File: rtl/pxc_rop.sv
module pxc_rop #(
  parameter int WORD_W = 24
) (
  input  logic [pxc_pkg::ROP_W-1:0] code,
  input  logic [WORD_W-1:0]         src,
  input  logic [WORD_W-1:0]         dst,
  output logic [WORD_W-1:0]         res
);
  // Each bit looks up the truth table with {dst, src} as index (R2).
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign res[i] = code[{dst[i], src[i]}];
  end
endmodule

// File: rtl/pxc_weight.sv
module pxc_weight #(
  parameter int CH_W = 8
) (
  input  pxc_pkg::blend_mode_e mode,
  input  logic [CH_W-1:0]      src_a,
  input  logic [CH_W-1:0]      dst_a,
  output logic [CH_W:0]        w_src,
  output logic [CH_W:0]        w_dst
);
  localparam logic [CH_W:0]   FULL = (CH_W+1)'(1) << CH_W;
  localparam logic [CH_W-1:0] AMAX = '1;

  logic [CH_W:0] sa_inc, da_inc, sa_inv, da_inv;

  assign sa_inc = {1'b0, src_a} + 1'b1;
  assign da_inc = {1'b0, dst_a} + 1'b1;
  assign sa_inv = {1'b0, AMAX - src_a};
  assign da_inv = {1'b0, AMAX - dst_a};

  // Every mode is reduced to a pair of weights over a divide by 2^CH_W.
  always_comb begin
    w_src = FULL;
    w_dst = '0;
    unique case (mode)
      pxc_pkg::BLEND_PASS: begin
        w_src = FULL;
        w_dst = '0;
      end
      pxc_pkg::BLEND_BY_SRC_A: begin
        if (src_a == '0) begin
          w_src = '0;
          w_dst = FULL;
        end else begin
          w_src = sa_inc;
          w_dst = sa_inv;
        end
      end
      pxc_pkg::BLEND_BY_DST_A: begin
        if (dst_a == '0) begin
          w_src = FULL;
          w_dst = '0;
        end else begin
          w_src = da_inv;
          w_dst = da_inc;
        end
      end
      pxc_pkg::BLEND_ADDITIVE: begin
        // alpha max gives max+1 = FULL, which is the full-scale case
        w_src = (src_a == '0) ? '0 : sa_inc;
        w_dst = (dst_a == '0) ? '0 : da_inc;
      end
      default: begin
        w_src = FULL;
        w_dst = '0;
      end
    endcase
  end
endmodule

// File: rtl/pxc_mac.sv
module pxc_mac #(
  parameter int CH_W  = 8,
  parameter int ACC_W = 2 * CH_W + 2
) (
  input  logic [CH_W-1:0]  r,
  input  logic [CH_W-1:0]  d,
  input  logic [CH_W:0]    w_src,
  input  logic [CH_W:0]    w_dst,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] p_src, p_dst;
  assign p_src = ACC_W'(r) * ACC_W'(w_src);
  assign p_dst = ACC_W'(d) * ACC_W'(w_dst);
  assign acc   = p_src + p_dst;
endmodule

// File: rtl/pxc_sat.sv
module pxc_sat #(
  parameter int CH_W  = 8,
  parameter int ACC_W = 2 * CH_W + 2
) (
  input  logic [ACC_W-1:0] acc,
  output logic [CH_W-1:0]  q
);
  localparam int Q_W = ACC_W - CH_W;
  logic [Q_W-1:0] quot;

  // Truncating divide by 2^CH_W, then clamp (only the additive mode can exceed).
  assign quot = acc[ACC_W-1:CH_W];
  assign q    = (quot[Q_W-1:CH_W] != '0) ? '1 : quot[CH_W-1:0];
endmodule

// File: rtl/pxc_top.sv
module pxc_top #(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NUM_CH*CH_W-1:0]   in_src,
  input  logic [CH_W-1:0]          in_src_alpha,
  input  logic [NUM_CH*CH_W-1:0]   in_dst,
  input  logic [CH_W-1:0]          in_dst_alpha,
  input  logic [3:0]               cfg_rop,
  input  logic [1:0]               cfg_blend,
  input  logic [NUM_CH*CH_W-1:0]   cfg_mask,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NUM_CH*CH_W-1:0]   out_pix
);
  localparam int PIX_W = NUM_CH * CH_W;
  localparam int ACC_W = 2 * CH_W + 2;
  localparam int FULL  = 1 << CH_W;

  // Global stall: every stage moves together when the last one can drain.
  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // ---------------- stage 1: raster op and weights ----------------
  logic [PIX_W-1:0] rop_res;
  logic [CH_W:0]    w_src_c, w_dst_c;

  pxc_rop #(.WORD_W(PIX_W)) u_rop (
    .code (cfg_rop),
    .src  (in_src),
    .dst  (in_dst),
    .res  (rop_res)
  );

  pxc_weight #(.CH_W(CH_W)) u_weight (
    .mode  (pxc_pkg::blend_mode_e'(cfg_blend)),
    .src_a (in_src_alpha),
    .dst_a (in_dst_alpha),
    .w_src (w_src_c),
    .w_dst (w_dst_c)
  );

  logic             s1_valid;
  logic [PIX_W-1:0] s1_r, s1_dst, s1_mask;
  logic [CH_W:0]    s1_ws, s1_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_r     <= '0;
      s1_dst   <= '0;
      s1_mask  <= '0;
      s1_ws    <= '0;
      s1_wd    <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      s1_r     <= rop_res;
      s1_dst   <= in_dst;
      s1_mask  <= cfg_mask;
      s1_ws    <= w_src_c;
      s1_wd    <= w_dst_c;
    end
  end

  // ---------------- stage 2: per-channel weighted sums ----------------
  logic [NUM_CH*ACC_W-1:0] acc_c;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mac
    pxc_mac #(.CH_W(CH_W), .ACC_W(ACC_W)) u_mac (
      .r     (s1_r[c*CH_W +: CH_W]),
      .d     (s1_dst[c*CH_W +: CH_W]),
      .w_src (s1_ws),
      .w_dst (s1_wd),
      .acc   (acc_c[c*ACC_W +: ACC_W])
    );
  end

  logic                    s2_valid;
  logic [NUM_CH*ACC_W-1:0] s2_acc;
  logic [PIX_W-1:0]        s2_dst, s2_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_acc   <= '0;
      s2_dst   <= '0;
      s2_mask  <= '0;
    end else if (advance) begin
      s2_valid <= s1_valid;
      s2_acc   <= acc_c;
      s2_dst   <= s1_dst;
      s2_mask  <= s1_mask;
    end
  end

  // ---------------- stage 3: divide, clamp, write mask ----------------
  logic [PIX_W-1:0] blend_c, merged_c;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sat
    pxc_sat #(.CH_W(CH_W), .ACC_W(ACC_W)) u_sat (
      .acc (s2_acc[c*ACC_W +: ACC_W]),
      .q   (blend_c[c*CH_W +: CH_W])
    );
  end

  assign merged_c = (blend_c & s2_mask) | (s2_dst & ~s2_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (advance) begin
      out_valid <= s2_valid;
      out_pix   <= merged_c;
    end
  end

  // ---------------- assertions ----------------
  // R9: a stalled result is held unchanged
  p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R7: bits outside the mask carry the destination through
  p_mask_keeps_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && advance) |=> (((out_pix ^ $past(s2_dst)) & ~$past(s2_mask)) == '0));

  // R4 / R5: the single-alpha modes use weights summing to full scale
  p_weight_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (cfg_blend == 2'b01 || cfg_blend == 2'b10))
      |=> ((32'(s1_ws) + 32'(s1_wd)) == FULL));

  // R8: a beat leaving stage 2 becomes a visible result
  p_fill_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && advance) |=> out_valid);

  // R6: additive mode with both alphas zero clears both weights
  p_add_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_blend == 2'b11 && in_src_alpha == '0 && in_dst_alpha == '0)
      |=> (s1_ws == '0 && s1_wd == '0));

endmodule

// File: tb/test_pxc_top.sv
module test_pxc_top;
  localparam int NCH = 3;
  localparam int CW  = 8;
  localparam int PW  = NCH * CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_src = '0, in_dst = '0, cfg_mask = '0;
  logic [CW-1:0] in_src_alpha = '0, in_dst_alpha = '0;
  logic [3:0]    cfg_rop = '0;
  logic [1:0]    cfg_blend = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PW-1:0] out_pix;

  always #2 clk = ~clk;

  pxc_top #(.NUM_CH(NCH), .CH_W(CW)) i_pxc_top (
    .clk, .rst_n, .in_valid, .in_ready, .in_src, .in_src_alpha,
    .in_dst, .in_dst_alpha, .cfg_rop, .cfg_blend, .cfg_mask,
    .out_valid, .out_ready, .out_pix
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int first_acc = 0;
  int out_cyc = 0;
  bit bp_rand = 1'b0;
  bit held = 1'b0;
  logic [PW-1:0] held_pix;
  logic [PW-1:0] exp_q[$];
  string         tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PW-1:0] model(
    input logic [PW-1:0] s, input logic [CW-1:0] sa,
    input logic [PW-1:0] d, input logic [CW-1:0] da,
    input logic [3:0] rop, input logic [1:0] mode, input logic [PW-1:0] m);
    logic [PW-1:0] r, b;
    for (int i = 0; i < PW; i++) r[i] = rop[{d[i], s[i]}];
    for (int c = 0; c < NCH; c++) begin
      int rv, dv, o, st, dt;
      rv = int'(r[c*CW +: CW]);
      dv = int'(d[c*CW +: CW]);
      case (mode)
        2'b00: o = rv;
        2'b01: o = (sa == 0) ? dv : ((int'(sa) + 1) * rv + (255 - int'(sa)) * dv) / 256;
        2'b10: o = (da == 0) ? rv : ((255 - int'(da)) * rv + (int'(da) + 1) * dv) / 256;
        default: begin
          st = (sa == 0) ? 0 : (sa == 255) ? rv * 256 : rv * (int'(sa) + 1);
          dt = (da == 0) ? 0 : (da == 255) ? dv * 256 : dv * (int'(da) + 1);
          o  = (st + dt) / 256;
          if (o > 255) o = 255;
        end
      endcase
      b[c*CW +: CW] = o[CW-1:0];
    end
    return (b & m) | (d & ~m);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic send(input logic [PW-1:0] s, input logic [CW-1:0] sa,
                      input logic [PW-1:0] d, input logic [CW-1:0] da,
                      input logic [3:0] rop, input logic [1:0] mode,
                      input logic [PW-1:0] m, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_src = s; in_src_alpha = sa; in_dst = d;
    in_dst_alpha = da; cfg_rop = rop; cfg_blend = mode; cfg_mask = m;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(s, sa, d, da, rop, mode, m));
    tag_q.push_back(tag);
    acc_cyc = cyc;
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
    // scramble inputs so a held beat cannot rely on them
    in_src = PW'($urandom); in_dst = PW'($urandom);
    cfg_rop = 4'($urandom); cfg_blend = 2'($urandom); cfg_mask = PW'($urandom);
  endtask

  task automatic drain();
    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
  endtask

  function automatic string mode_tag(input logic [1:0] mode);
    case (mode)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  // sink back-pressure
  always @(negedge clk) out_ready = bp_rand ? (($urandom % 3) != 0) : 1'b1;

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (held) begin
        check(out_valid && out_pix == held_pix, "R9", "stalled output changed",
              32'(out_pix), 32'(held_pix));
        held = 1'b0;
      end
      if (out_valid && !out_ready) begin
        check(!in_ready, "R9", "in_ready during stall", 32'(in_ready), 32'd0);
        held = 1'b1;
        held_pix = out_pix;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "result with no beat in flight", 32'(out_pix), 32'd0);
        end else begin
          logic [PW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_pix == e, t, "pixel", 32'(out_pix), 32'(e));
          out_cyc = cyc;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R8 watchdog: run hung, actual %0d cycles expected fewer", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [PW-1:0] SP = 24'hCC_A5_33;
  localparam logic [PW-1:0] DP = 24'hAA_5A_0F;

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check(!out_valid && in_ready, "R1", "in reset out_valid/in_ready",
          {30'd0, out_valid, in_ready}, 32'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready, "R1", "in_ready after reset", 32'(in_ready), 32'd1);

    // R8: single beat latency
    send(SP, 8'd0, DP, 8'd0, 4'b1010, 2'b00, '1, "R8");
    go_idle();
    drain();
    check(out_cyc - acc_cyc == 3, "R8", "latency in cycles", 32'(out_cyc - acc_cyc), 32'd3);

    // R8: back-to-back throughput
    for (int i = 0; i < 6; i++) begin
      send(PW'($urandom), 8'($urandom), PW'($urandom), 8'($urandom),
           4'($urandom), 2'($urandom), '1, "R8");
      if (i == 0) first_acc = acc_cyc;
    end
    go_idle();
    drain();
    check(out_cyc - first_acc == 8, "R8", "burst of 6 finish cycle",
          32'(out_cyc - first_acc), 32'd8);

    // R2: every raster code, full mask, pass mode
    for (int c = 0; c < 16; c++) send(SP, 8'd77, DP, 8'd99, 4'(c), 2'b00, '1, "R2");

    // R3: mode 00 ignores alpha
    send(SP, 8'd0, DP, 8'd200, 4'b1010, 2'b00, '1, "R3");
    send(SP, 8'd255, DP, 8'd0, 4'b0110, 2'b00, '1, "R3");

    // R4: source-alpha blend corners
    send(SP, 8'd0,   DP, 8'd50, 4'b1010, 2'b01, '1, "R4");
    send(SP, 8'd1,   DP, 8'd50, 4'b1010, 2'b01, '1, "R4");
    send(SP, 8'd128, DP, 8'd50, 4'b1010, 2'b01, '1, "R4");
    send(SP, 8'd255, DP, 8'd50, 4'b1010, 2'b01, '1, "R4");

    // R5: destination-alpha blend corners
    send(SP, 8'd9, DP, 8'd0,   4'b1010, 2'b10, '1, "R5");
    send(SP, 8'd9, DP, 8'd1,   4'b1010, 2'b10, '1, "R5");
    send(SP, 8'd9, DP, 8'd254, 4'b1010, 2'b10, '1, "R5");
    send(SP, 8'd9, DP, 8'd255, 4'b1010, 2'b10, '1, "R5");

    // R6: additive mode including saturation and zero weights
    send(24'hFF_FF_FF, 8'd255, 24'hFF_80_01, 8'd255, 4'b1010, 2'b11, '1, "R6");
    send(SP, 8'd0, DP, 8'd0, 4'b1010, 2'b11, '1, "R6");
    send(SP, 8'd100, DP, 8'd200, 4'b1110, 2'b11, '1, "R6");
    send(SP, 8'd255, DP, 8'd0, 4'b1010, 2'b11, '1, "R6");

    // R7: partial write masks
    send(SP, 8'd0, DP, 8'd0, 4'b1111, 2'b00, 24'h00_FF_00, "R7");
    send(SP, 8'd0, DP, 8'd0, 4'b0000, 2'b00, 24'hF0_0F_81, "R7");
    send(SP, 8'd128, DP, 8'd77, 4'b1010, 2'b01, 24'h00_00_00, "R7");
    go_idle();
    drain();

    // R10: configuration changes every beat under back-pressure
    bp_rand = 1'b1;
    for (int i = 0; i < 40; i++)
      send(SP, 8'($urandom), DP, 8'($urandom), 4'(i), 2'(i), PW'($urandom), "R10");
    go_idle();
    drain();

    // constrained random with alpha corners mixed in
    for (int i = 0; i < 3000; i++) begin
      logic [CW-1:0] sa, da;
      logic [1:0] md;
      int pick;
      pick = $urandom % 8;
      sa = (pick == 0) ? 8'd0 : (pick == 1) ? 8'd255 : 8'($urandom);
      pick = $urandom % 8;
      da = (pick == 0) ? 8'd0 : (pick == 1) ? 8'd255 : 8'($urandom);
      md = 2'($urandom);
      send(PW'($urandom), sa, PW'($urandom), da, 4'($urandom), md,
           (($urandom % 4) == 0) ? PW'($urandom) : '1, mode_tag(md));
      if (($urandom % 16) == 0) go_idle();
    end
    go_idle();
    drain();
    check(exp_q.size() == 0, "R9", "beats left in flight", 32'(exp_q.size()), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule